// File: doc/BRIEF.md
# Line Scan-Out Engine with Row Repetition

This block turns a stored frame of 8-bit pixels into a paced stream of colour values for a raster display. A line sequencer outside the block pulses `line_start` at the beginning of every display line and presents the line number alongside it. A negative number marks a line with no picture. On a picture line the engine reads a fixed count of pixels from an external synchronous memory, starting at that line's row address. It shows each pixel for a programmable number of clocks, and only while the horizontal pixel window is open. After the last pixel it returns the colour to black and raises a one-clock end-of-line pulse.

Vertical scaling comes from row repetition. Each stored row is shown on 2, 3 or 6 consecutive display lines. The engine moves the row address on by one row length when a repeat group ends. Line 0 reloads the row address from the frame base. The frame memory sits outside the block and answers each read on the clock after the request.

Top module: `line_scanout`

## Requirements
- R1: While reset is high and on the first clock after it, `color` is 0, `eol` is 0 and `rd_en` is 0.
- R2: On a line whose number is zero or positive, exactly `pix_per_row` reads are issued, at consecutive addresses starting at the line's row address. Each read is issued with `pix_win` high.
- R3: After a line start, the pixel divider counts from zero. It advances only on clocks where `pix_win` is high and `line_start` is low. A read is issued on every (`pix_ticks`)-th such clock, starting with the first.
- R4: Each fetched pixel appears on `color` two clocks after its read request. It is held until the next pixel replaces it.
- R5: On the divider slot after the last pixel, the end of the line is marked. Two clocks later `color` becomes 0 and `eol` is high for exactly one clock. When `pix_per_row` is 0, this happens on the first slot.
- R6: After a `line_start` with a negative line number, no read is issued, `color` stays 0 and `eol` stays low until the next line start.
- R7: A `line_start` forces `color` to 0 and `eol` low on the next clock, and discards any pixel still in flight.
- R8: Line 0 takes its row address from `frame_base`. The row address then moves up by `pix_per_row` after each group of repeated lines. The group size is set by `rep_mode`: 0 gives 2 lines, 1 gives 3, 2 gives 6 and 3 gives 2.
- R9: A `frame_base` value changed after line 0 has no effect until the next line 0.
- R10: A `pix_ticks` value of 0 paces pixels like a value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-clock pulse at the start of each display line |
| line_num | input | LINE_W | Signed line number sampled with `line_start`; negative means no picture |
| pix_win | input | 1 | Horizontal pixel window; the divider runs only while high |
| frame_base | input | ADDR_W | Address of the first stored row, taken at line 0 |
| pix_per_row | input | PPR_W | Pixels per stored row, taken at each line start |
| pix_ticks | input | TICK_W | Clocks per pixel, taken at each line start |
| rep_mode | input | 2 | Row repeat selection |
| rd_en | output | 1 | Frame memory read request |
| rd_addr | output | ADDR_W | Frame memory read address |
| rd_data | input | PIX_W | Frame memory data, valid the clock after the request |
| color | output | PIX_W | Registered pixel colour |
| eol | output | 1 | One-clock end-of-line pulse |

## Verification
A read request and its address are due in the same clock as the divider slot that causes them. The pixel it fetches reaches `color` on the second rising edge after that. The end-of-line black and the `eol` pulse follow the end slot by the same two edges. The row address and the cleared output take effect on the edge that samples `line_start`. The bench's reference model steps on each rising edge with these delays, and all outputs are compared one nanosecond after every edge. That way each result is read in the clock it is due and never at an edge.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    REP_X2  = 2'd0,
    REP_X3  = 2'd1,
    REP_X6  = 2'd2,
    REP_X2B = 2'd3
  } rep_mode_e;

  function automatic logic [2:0] repeat_factor(input logic [1:0] mode);
    case (rep_mode_e'(mode))
      REP_X3:  repeat_factor = 3'd3;
      REP_X6:  repeat_factor = 3'd6;
      default: repeat_factor = 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/lsc_tick_div.sv
module lsc_tick_div #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [TICK_W-1:0] ticks,
  input  logic              run,
  output logic              slot
);
  logic [TICK_W-1:0] cnt;
  logic [TICK_W-1:0] lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lim <= '0;
    end else if (restart) begin
      cnt <= '0;
      lim <= (ticks == '0) ? '0 : ticks - 1'b1;
    end else if (run) begin
      cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
  end

  assign slot = run && !restart && (cnt == '0);
endmodule

// File: rtl/lsc_row_seq.sv
module lsc_row_seq
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PPR_W  = 10,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic [ADDR_W-1:0] frame_base,
  input  logic [PPR_W-1:0]  pix_per_row,
  input  logic [1:0]        rep_mode,
  output logic [ADDR_W-1:0] line_addr
);
  logic [ADDR_W-1:0] next_row;
  logic [2:0]        rep_cnt;
  logic              first_line;
  logic              picture_line;
  logic [ADDR_W-1:0] cur_row;
  logic [2:0]        cnt_now;
  logic              group_end;

  always_comb begin
    first_line   = (line_num == '0);
    picture_line = !line_num[LINE_W-1];
    cur_row      = first_line ? frame_base : next_row;
    cnt_now      = first_line ? 3'd0 : rep_cnt;
    group_end    = (cnt_now == repeat_factor(rep_mode) - 3'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_addr <= '0;
      next_row  <= '0;
      rep_cnt   <= '0;
    end else if (line_start && picture_line) begin
      line_addr <= cur_row;
      if (group_end) begin
        next_row <= cur_row + ADDR_W'(pix_per_row);
        rep_cnt  <= '0;
      end else begin
        next_row <= cur_row;
        rep_cnt  <= cnt_now + 3'd1;
      end
    end
  end
endmodule

// File: rtl/lsc_pixel_fetch.sv
module lsc_pixel_fetch #(
  parameter int ADDR_W = 16,
  parameter int PPR_W  = 10,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              line_ok,
  input  logic [PPR_W-1:0]  pix_per_row,
  input  logic              slot,
  input  logic [ADDR_W-1:0] line_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic              active,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [PIX_W-1:0]  color,
  output logic              eol
);
  logic [PPR_W-1:0] pix_cnt;
  logic [PPR_W-1:0] ppr_q;
  logic             st_v;
  logic             st_end;
  logic             req;
  logic             more;

  assign req     = slot && active;
  assign more    = (pix_cnt != ppr_q);
  assign rd_en   = req && more;
  assign rd_addr = line_addr + ADDR_W'(pix_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      pix_cnt <= '0;
      ppr_q   <= '0;
      st_v    <= 1'b0;
      st_end  <= 1'b0;
      color   <= '0;
      eol     <= 1'b0;
    end else if (line_start) begin
      active  <= line_ok;
      pix_cnt <= '0;
      ppr_q   <= pix_per_row;
      st_v    <= 1'b0;
      st_end  <= 1'b0;
      color   <= '0;
      eol     <= 1'b0;
    end else begin
      st_v   <= req;
      st_end <= req && !more;
      eol    <= st_v && st_end;
      if (rd_en) pix_cnt <= pix_cnt + 1'b1;
      if (req && !more) active <= 1'b0;
      if (st_v) color <= st_end ? '0 : rd_data;
    end
  end
endmodule

// File: rtl/line_scanout.sv
module line_scanout #(
  parameter int ADDR_W = 16,
  parameter int PPR_W  = 10,
  parameter int TICK_W = 8,
  parameter int LINE_W = 11,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              pix_win,
  input  logic [ADDR_W-1:0] frame_base,
  input  logic [PPR_W-1:0]  pix_per_row,
  input  logic [TICK_W-1:0] pix_ticks,
  input  logic [1:0]        rep_mode,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic [PIX_W-1:0]  color,
  output logic              eol
);
  logic              active;
  logic              slot;
  logic [ADDR_W-1:0] line_addr;

  lsc_tick_div #(.TICK_W(TICK_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (line_start),
    .ticks   (pix_ticks),
    .run     (active && pix_win),
    .slot    (slot)
  );

  lsc_row_seq #(.ADDR_W(ADDR_W), .PPR_W(PPR_W), .LINE_W(LINE_W)) u_row (
    .clk         (clk),
    .rst         (rst),
    .line_start  (line_start),
    .line_num    (line_num),
    .frame_base  (frame_base),
    .pix_per_row (pix_per_row),
    .rep_mode    (rep_mode),
    .line_addr   (line_addr)
  );

  lsc_pixel_fetch #(.ADDR_W(ADDR_W), .PPR_W(PPR_W), .PIX_W(PIX_W)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .line_start  (line_start),
    .line_ok     (!line_num[LINE_W-1]),
    .pix_per_row (pix_per_row),
    .slot        (slot),
    .line_addr   (line_addr),
    .rd_data     (rd_data),
    .active      (active),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .color       (color),
    .eol         (eol)
  );
endmodule

// File: rtl/line_scanout_chk.sv
module line_scanout_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             line_start,
  input logic             line_neg,
  input logic             pix_win,
  input logic             rd_en,
  input logic [PIX_W-1:0] color,
  input logic             eol
);
  logic idle_line;

  always_ff @(posedge clk) begin
    if (rst) idle_line <= 1'b0;
    else if (line_start) idle_line <= line_neg;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (color == '0 && !eol && !rd_en));

  a_r2_read_in_window: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (pix_win && !line_start));

  a_r5_eol_black: assert property (@(posedge clk) disable iff (rst)
    eol |-> (color == '0));

  a_r5_eol_single: assert property (@(posedge clk) disable iff (rst)
    eol |=> !eol);

  a_r6_idle_no_read: assert property (@(posedge clk) disable iff (rst)
    idle_line |-> (!rd_en && !eol && color == '0));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (color == '0 && !eol));
endmodule

bind line_scanout line_scanout_chk #(.PIX_W(PIX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .line_start (line_start),
  .line_neg   (line_num[LINE_W-1]),
  .pix_win    (pix_win),
  .rd_en      (rd_en),
  .color      (color),
  .eol        (eol)
);

// File: tb/sim_line_scanout.sv
`timescale 1ns/100ps
module sim_line_scanout;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ls = 1'b0;
  logic [10:0] ln = '0;
  logic        win = 1'b0;
  logic [15:0] base = '0;
  logic [9:0]  ppr = '0;
  logic [7:0]  ticks = '0;
  logic [1:0]  mode = '0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic [7:0]  color;
  logic        eol;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  line_scanout u0 (
    .clk(clk), .rst(rst), .line_start(ls), .line_num(ln), .pix_win(win),
    .frame_base(base), .pix_per_row(ppr), .pix_ticks(ticks), .rep_mode(mode),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .color(color), .eol(eol)
  );

  function automatic int pix_of(int a);
    return ((a & 16'hFFFF) * 7 + 3) & 8'hFF;
  endfunction

  function automatic int fac(int m);
    return (m == 1) ? 3 : (m == 2) ? 6 : 2;
  endfunction

  // frame memory: answers the clock after the request
  always @(posedge clk) rd_data <= 8'(pix_of(int'(rd_addr)));

  // behavioural reference model
  int m_active = 0, m_tick = 0, m_lim = 1, m_pix = 0, m_ppr = 0;
  int m_base = 0, m_row = 0, m_line = -1, m_color = 0, m_eol = 0;
  int s_v = 0, s_end = 0, s_val = 0;
  int lnum;

  always @(posedge clk) begin
    lnum = int'($signed(ln));
    if (rst) begin
      m_active = 0; m_color = 0; m_eol = 0; s_v = 0; m_line = -1;
    end else if (ls) begin
      m_color = 0; m_eol = 0; s_v = 0; m_tick = 0; m_pix = 0;
      m_lim = (ticks == 0) ? 1 : int'(ticks);
      m_ppr = int'(ppr);
      m_active = (lnum >= 0);
      m_line = lnum;
      if (lnum == 0) m_base = int'(base);
      if (lnum >= 0) m_row = (m_base + (lnum / fac(int'(mode))) * int'(ppr)) & 16'hFFFF;
    end else begin
      m_eol = 0;
      if (s_v != 0) begin
        if (s_end != 0) begin m_color = 0; m_eol = 1; end
        else m_color = s_val;
      end
      s_v = 0;
      if (m_active != 0 && win) begin
        if (m_tick == 0) begin
          s_v = 1;
          if (m_pix < m_ppr) begin
            s_end = 0; s_val = pix_of(m_row + m_pix); m_pix++;
          end else begin
            s_end = 1; m_active = 0;
          end
        end
        m_tick = (m_tick + 1) % m_lim;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // compare every clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      bit e_rd;
      e_rd = (m_active != 0) && win && !ls && (m_tick == 0) && (m_pix < m_ppr);
      chk(rd_en == e_rd, (m_line < 0) ? "R6 rd_en" : "R2/R3 rd_en", int'(rd_en), int'(e_rd));
      if (e_rd && rd_en)
        chk(int'(rd_addr) == ((m_row + m_pix) & 16'hFFFF), "R8/R9 rd_addr",
            int'(rd_addr), (m_row + m_pix) & 16'hFFFF);
      chk(int'(color) == m_color, "R4/R5/R7 color", int'(color), m_color);
      chk(int'(eol) == m_eol, "R5 eol", int'(eol), m_eol);
    end
  end

  task automatic do_line(int n, int gap_at);
    int lim;
    lim = (ticks == 0) ? 1 : int'(ticks);
    @(negedge clk); ls = 1'b1; ln = 11'(n);
    @(negedge clk); ls = 1'b0;
    repeat (3) @(negedge clk);
    win = 1'b1;
    for (int i = 0; i < int'(ppr) * lim + 3; i++) begin
      if (i == gap_at) begin
        win = 1'b0; repeat (3) @(negedge clk); win = 1'b1;
      end
      @(negedge clk);
    end
    win = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(color == 0, "R1 color", int'(color), 0);
    chk(eol == 0, "R1 eol", int'(eol), 0);
    chk(rd_en == 0, "R1 rd_en", int'(rd_en), 0);
    rst = 1'b0;

    // frame A: double rows, 3 clocks per pixel, window gap, mid-frame base change (R9)
    mode = 2'd0; ppr = 10'd5; ticks = 8'd3; base = 16'h0100;
    do_line(-2, -1); do_line(-1, -1);             // R6
    for (int l = 0; l < 6; l++) begin
      if (l == 3) base = 16'h0800;                 // R9: ignored until line 0
      do_line(l, (l == 2) ? 4 : -1);               // R3 gap on line 2
    end

    // frame B: triple rows, 1 clock per pixel, base 0x0800 now taken (R8, R9)
    mode = 2'd1; ppr = 10'd4; ticks = 8'd1;
    do_line(-1, -1);
    for (int l = 0; l < 7; l++) do_line(l, -1);

    // frame C: six-line rows, ticks 0 behaves as 1 (R10)
    mode = 2'd2; ppr = 10'd3; ticks = 8'd0; base = 16'h2000;
    for (int l = 0; l < 13; l++) do_line(l, -1);

    // frame D: mode code 3 repeats twice, near address wrap
    mode = 2'd3; ppr = 10'd2; ticks = 8'd2; base = 16'hFFFC;
    for (int l = 0; l < 5; l++) do_line(l, -1);

    // empty row: end of line on the first slot (R5)
    ppr = 10'd0;
    do_line(0, -1);

    // R7: line start cuts a line short
    ppr = 10'd6; ticks = 8'd2; base = 16'h0040;
    @(negedge clk); ls = 1'b1; ln = 11'd0;
    @(negedge clk); ls = 1'b0; win = 1'b1;
    repeat (7) @(negedge clk);
    ls = 1'b1; ln = 11'd1;
    @(negedge clk); ls = 1'b0;
    repeat (30) @(negedge clk);
    win = 1'b0;
    repeat (6) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule